// File: doc/BRIEF.md
# Register-Write Command Replay Engine

This block pulls a queue of register-write commands out of memory and plays them onto an internal register-write port. Software sets an enable bit and a start pointer. It then writes an end pointer, and that write launches the run. The engine reads one 64-bit slot at a time, from the start pointer up to but not including the end pointer. It decodes each slot and issues address/data/byte-enable writes. The queue can hold only writes; nothing in it reads a register.

Two command shapes exist. A single write takes one slot: the low word is the value, and the high word carries the opcode, the byte lanes and the register offset. A burst write starts with a slot holding a word count and a target offset. The data words that follow fill later slots, low word first, and all of them go to that one offset. A zero word pads a burst that would end halfway through a slot. Software pads the queue to whole 64-byte blocks with zero slots, and the engine skips those slots. An opcode the engine does not know halts the run and sets a sticky error flag.

The memory read side and the register-write side both use valid/ready handshakes. A request, a response or a write counts only on a clock edge where valid and ready are both high. While valid is high and ready is low, the sender keeps valid high and holds its payload unchanged. The engine keeps one read in flight at a time, so the memory may take any number of cycles to answer. The configuration port is a plain write strobe with a select field.

Top module: `cmd_replay_engine`

## Requirements
- R1: After reset, `busy`, `error` and `enabled` are 0, and neither `rd_req_valid` nor `wr_valid` is asserted.
- R2: A configuration write with `cfg_sel`=0 sets `enabled` from `cfg_wdata[0]`. A write with `cfg_sel`=1 loads the start pointer. A write with `cfg_sel`=2 loads the end pointer. It starts a run only if `enabled` is 1 and the new end pointer differs from the start pointer. `busy` is 1 from the cycle after that write until the run ends.
- R3: While `busy` is 1, every configuration write is ignored. `enabled`, the start pointer and the end pointer all keep their values.
- R4: A run requests byte addresses start, start+8, start+16 and so on, one request at a time. It stops after the slot just below the end pointer. No request is made at or beyond the end pointer.
- R5: A slot whose high word has bits 31:24 = 0x01 is a single write. It produces one write with `wr_addr` = high word bits 19:0, `wr_be` = high word bits 23:20 and `wr_data` = the low word.
- R6: A slot whose high word has bits 31:24 = 0x09 opens a burst. Its low word N is the count and high word bits 19:0 is the offset. The next N words, taken as low word then high word of each following slot, each produce one write to that offset with `wr_be`=4'hF. A pad word left over in the last slot produces no write. N=0 produces no write.
- R7: A slot whose high word has bits 31:24 = 0x00, outside a burst, produces no write.
- R8: Any other opcode sets `error`. In the same cycle it ends the run, and no further request or write follows. `error` stays set until the next run starts, and starting a run clears it.
- R9: While `rd_req_valid` or `wr_valid` is high and its ready input is low, the valid stays high and the payload does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 control, 1 start pointer, 2 end pointer |
| cfg_wdata | input | ADDR_W | Configuration write data |
| enabled | output | 1 | Current enable bit |
| busy | output | 1 | Run in progress |
| error | output | 1 | Sticky unknown-opcode flag |
| rd_req_valid | output | 1 | Slot read request valid |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_req_addr | output | ADDR_W | Byte address of requested slot |
| rd_rsp_valid | input | 1 | Slot data valid |
| rd_rsp_ready | output | 1 | Engine accepts slot data |
| rd_rsp_data | input | 64 | Slot contents, low word = lower address |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register port accepts write |
| wr_addr | output | 20 | Register offset |
| wr_data | output | 32 | Register write value |
| wr_be | output | 4 | Byte enables |

## Verification
Suppose a burst counter or a lane pointer holds the wrong value. The effect appears on the very next accepted write as a wrong value or a wrong offset, or, a few slots later, as writes that are missing or extra. Suppose the fetch address or the end compare holds the wrong value. Then the next request lands at an unexpected address, or the engine makes more or fewer requests than the queue length. Suppose a configuration write slips through during a run. Then `enabled` changes at once, or a later run replays a queue from the wrong place. The per-clock comparison against a queue of expected writes and request addresses catches each of these on the handshake where it first appears.

// File: rtl/cre_pkg.sv
package cre_pkg;
  localparam int WORD_W = 32;
  localparam int SLOT_W = 2 * WORD_W;
  localparam int OFS_W  = 20;
  localparam int BE_W   = 4;
  localparam int OPC_W  = 8;

  localparam logic [OPC_W-1:0] OPC_NOP     = 8'h00;
  localparam logic [OPC_W-1:0] OPC_SINGLE  = 8'h01;
  localparam logic [OPC_W-1:0] OPC_BURST   = 8'h09;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HEAD = 2'd1,
    SEL_TAIL = 2'd2
  } cfg_sel_e;

  typedef enum logic [1:0] {
    F_IDLE,
    F_REQ,
    F_WAIT,
    F_HOLD
  } fetch_st_e;
endpackage

// File: rtl/cre_regs.sv
module cre_regs
  import cre_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              busy,
  output logic              enable,
  output logic [ADDR_W-1:0] head,
  output logic [ADDR_W-1:0] tail,
  output logic              start
);
  cfg_sel_e sel;
  logic     accept;

  assign sel    = cfg_sel_e'(cfg_sel);
  assign accept = cfg_wr_en && !busy;
  assign start  = accept && (sel == SEL_TAIL) && enable && (cfg_wdata != head);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
      head   <= '0;
      tail   <= '0;
    end else if (accept) begin
      case (sel)
        SEL_CTRL: enable <= cfg_wdata[0];
        SEL_HEAD: head   <= cfg_wdata;
        SEL_TAIL: tail   <= cfg_wdata;
        default:  ;
      endcase
    end
  end

  // R3: configuration is frozen while a run is in progress
  assert_busy_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_wr_en |=> $stable(head) && $stable(tail) && $stable(enable));
endmodule

// File: rtl/cre_fetch.sv
module cre_fetch
  import cre_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] head,
  input  logic [ADDR_W-1:0] tail,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [SLOT_W-1:0] rd_rsp_data,
  output logic              slot_valid,
  output logic [SLOT_W-1:0] slot,
  input  logic              slot_done,
  input  logic              slot_err,
  output logic              busy
);
  localparam int STEP = SLOT_W / 8;

  fetch_st_e         st;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] nxt;

  assign nxt          = addr + ADDR_W'(STEP);
  assign rd_req_valid = (st == F_REQ);
  assign rd_req_addr  = addr;
  assign rd_rsp_ready = (st == F_WAIT);
  assign slot_valid   = (st == F_HOLD);
  assign busy         = (st != F_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= F_IDLE;
      addr <= '0;
      slot <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          addr <= head;
          st   <= F_REQ;
        end
        F_REQ:  if (rd_req_ready) st <= F_WAIT;
        F_WAIT: if (rd_rsp_valid) begin
          slot <= rd_rsp_data;
          st   <= F_HOLD;
        end
        F_HOLD: if (slot_done) begin
          if (slot_err || nxt == tail) begin
            st <= F_IDLE;
          end else begin
            addr <= nxt;
            st   <= F_REQ;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // R9: a pending request keeps its address
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  // R4: no request is issued at the end pointer
  assert_req_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr != tail);
endmodule

// File: rtl/cre_decode.sv
module cre_decode
  import cre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              slot_valid,
  input  logic [SLOT_W-1:0] slot,
  output logic              slot_done,
  output logic              slot_err,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [OFS_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be
);
  logic [WORD_W-1:0] lo_w;
  logic [WORD_W-1:0] hi_w;
  logic [OPC_W-1:0]  opc;
  logic              in_burst;
  logic              lane;
  logic [WORD_W-1:0] remain;
  logic [OFS_W-1:0]  burst_ofs;
  logic              last_word;

  assign lo_w      = slot[WORD_W-1:0];
  assign hi_w      = slot[SLOT_W-1:WORD_W];
  assign opc       = hi_w[WORD_W-1 -: OPC_W];
  assign last_word = (remain == WORD_W'(1));

  always_comb begin
    slot_done = 1'b0;
    slot_err  = 1'b0;
    wr_valid  = 1'b0;
    wr_addr   = '0;
    wr_data   = '0;
    wr_be     = '0;
    if (slot_valid) begin
      if (in_burst) begin
        wr_valid  = 1'b1;
        wr_addr   = burst_ofs;
        wr_data   = lane ? hi_w : lo_w;
        wr_be     = '1;
        slot_done = wr_ready && (last_word || lane);
      end else begin
        case (opc)
          OPC_NOP:    slot_done = 1'b1;
          OPC_SINGLE: begin
            wr_valid  = 1'b1;
            wr_addr   = hi_w[OFS_W-1:0];
            wr_data   = lo_w;
            wr_be     = hi_w[OFS_W +: BE_W];
            slot_done = wr_ready;
          end
          OPC_BURST:  slot_done = 1'b1;
          default: begin
            slot_done = 1'b1;
            slot_err  = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_burst  <= 1'b0;
      lane      <= 1'b0;
      remain    <= '0;
      burst_ofs <= '0;
    end else if (start) begin
      in_burst <= 1'b0;
      lane     <= 1'b0;
      remain   <= '0;
    end else if (slot_valid) begin
      if (in_burst) begin
        if (wr_ready) begin
          remain <= remain - WORD_W'(1);
          if (last_word) begin
            in_burst <= 1'b0;
            lane     <= 1'b0;
          end else begin
            lane <= ~lane;
          end
        end
      end else if (opc == OPC_BURST && lo_w != '0) begin
        in_burst  <= 1'b1;
        remain    <= lo_w;
        burst_ofs <= hi_w[OFS_W-1:0];
        lane      <= 1'b0;
      end
    end
  end

  // R9: a stalled write keeps its payload
  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be));
endmodule

// File: rtl/cmd_replay_engine.sv
module cmd_replay_engine
  import cre_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              enabled,
  output logic              busy,
  output logic              error,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [SLOT_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [OFS_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be
);
  logic [ADDR_W-1:0] head;
  logic [ADDR_W-1:0] tail;
  logic              start;
  logic              slot_valid;
  logic [SLOT_W-1:0] slot;
  logic              slot_done;
  logic              slot_err;

  cre_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .enable    (enabled),
    .head      (head),
    .tail      (tail),
    .start     (start)
  );

  cre_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .head         (head),
    .tail         (tail),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_ready (rd_rsp_ready),
    .rd_rsp_data  (rd_rsp_data),
    .slot_valid   (slot_valid),
    .slot         (slot),
    .slot_done    (slot_done),
    .slot_err     (slot_err),
    .busy         (busy)
  );

  cre_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .slot_valid (slot_valid),
    .slot       (slot),
    .slot_done  (slot_done),
    .slot_err   (slot_err),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_be      (wr_be)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      error <= 1'b0;
    else if (start)                  error <= 1'b0;
    else if (slot_done && slot_err)  error <= 1'b1;
  end

  // R8: the cycle the error appears, the run is already over
  assert_err_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> !busy && !rd_req_valid && !wr_valid);
  // R5: writes only come out during a run
  assert_write_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);
endmodule

// File: tb/cmd_replay_engine_test.sv
`timescale 1ns/1ps
module cmd_replay_engine_test;
  import cre_pkg::*;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          enabled, busy, error;
  logic          rd_req_valid, rd_rsp_ready, wr_valid;
  logic          rd_req_ready = 1'b0;
  logic          rd_rsp_valid = 1'b0;
  logic [63:0]   rd_rsp_data = '0;
  logic          wr_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic [19:0]   wr_addr;
  logic [31:0]   wr_data;
  logic [3:0]    wr_be;

  always #4 clk = ~clk;

  cmd_replay_engine #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .enabled(enabled), .busy(busy), .error(error),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  typedef struct packed {
    logic [19:0] a;
    logic [31:0] d;
    logic [3:0]  be;
  } wr_t;

  wr_t         expq[$];
  logic [31:0] words[$];
  logic [63:0] mem[int];
  int          total = 0;
  int          bad = 0;
  bit          record = 1'b1;
  bit          finished = 1'b0;
  logic [31:0] exp_req = '0;
  int          req_cnt = 0;
  int          wr_cnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural memory, write sink and per-clock comparison
  initial begin : responder
    bit          req_fire, rsp_fire, wr_fire, held;
    logic [31:0] req_a, pend_a;
    wr_t         got, held_w;
    bit          pending;
    int          lat;
    req_fire = 0; rsp_fire = 0; wr_fire = 0; held = 0;
    req_a = '0; pend_a = '0; got = '0; held_w = '0; pending = 0; lat = 0;
    forever begin
      @(negedge clk);
      if (req_fire) begin
        check(req_a == exp_req, "R4", "request address", 64'(req_a), 64'(exp_req));
        exp_req = exp_req + 32'd8;
        req_cnt++;
        pending = 1;
        lat = int'($urandom % 4);
        pend_a = req_a;
      end
      if (rsp_fire) begin
        pending = 0;
        rd_rsp_valid = 1'b0;
      end
      if (wr_fire) begin
        wr_cnt++;
        if (expq.size() == 0) begin
          check(1'b0, "R6", "unexpected write", 64'(got), 64'(0));
        end else begin
          wr_t e;
          e = expq.pop_front();
          check(got == e, "R5", "write payload", 64'(got), 64'(e));
        end
      end
      rd_req_ready = !pending && ($urandom % 3 != 0);
      if (pending && !rd_rsp_valid) begin
        if (lat == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = mem.exists(int'(pend_a >> 3)) ? mem[int'(pend_a >> 3)] : 64'd0;
        end else begin
          lat--;
        end
      end
      wr_ready = ($urandom % 4 != 0);
      #1;
      if (held) check(wr_valid && ({wr_addr, wr_data, wr_be} == held_w), "R9", "stalled write held",
                      64'({wr_addr, wr_data, wr_be}), 64'(held_w));
      req_fire = rd_req_valid && rd_req_ready;
      req_a    = rd_req_addr;
      rsp_fire = rd_rsp_valid && rd_rsp_ready;
      wr_fire  = wr_valid && wr_ready;
      got      = {wr_addr, wr_data, wr_be};
      held     = wr_valid && !wr_ready;
      held_w   = got;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic put_single(input logic [19:0] ofs, input logic [31:0] d, input logic [3:0] be);
    words.push_back(d);
    words.push_back({OPC_SINGLE, be, ofs});
    if (record) expq.push_back({ofs, d, be});
  endtask

  task automatic put_burst(input logic [19:0] ofs, input int n, input logic [31:0] seed);
    words.push_back(32'(n));
    words.push_back({OPC_BURST, 4'h0, ofs});
    for (int i = 0; i < n; i++) begin
      words.push_back(seed + 32'(i * 7));
      if (record) expq.push_back({ofs, seed + 32'(i * 7), 4'hF});
    end
    if (words.size() % 2 != 0) words.push_back(32'd0);
  endtask

  task automatic load(input logic [31:0] base, output logic [31:0] len);
    while (words.size() % 16 != 0) words.push_back(32'd0);
    for (int i = 0; i < words.size(); i += 2)
      mem[int'(base >> 3) + i / 2] = {words[i+1], words[i]};
    len = 32'(words.size() * 4);
    words.delete();
  endtask

  task automatic start_run(input logic [31:0] head, input logic [31:0] tail_a);
    exp_req = head; req_cnt = 0; wr_cnt = 0;
    cfg_write(SEL_TAIL, tail_a);
    check(busy == 1'b1, "R2", "busy after end-pointer write", 64'(busy), 64'd1);
  endtask

  task automatic finish_run(input int exp_reqs);
    int guard;
    guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(!busy, "R2", "busy cleared at run end", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R5", "expected writes left", 64'(expq.size()), 64'd0);
    check(req_cnt == exp_reqs, "R4", "slot requests in run", 64'(req_cnt), 64'(exp_reqs));
  endtask

  task automatic build_main();
    put_single(20'h00123, 32'hDEADBEEF, 4'hF);
    put_single(20'hFFFFF, 32'h00000001, 4'b0101);
    put_burst(20'h00400, 3, 32'h1000_0000);   // odd count, pad word (R6)
    put_burst(20'h00500, 2, 32'h2000_0000);   // even count, no pad (R6)
    put_burst(20'h00600, 0, 32'h0);           // zero count (R6)
    words.push_back(32'd0); words.push_back(32'd0);   // opcode 0 slot (R7)
    put_single(20'h00010, 32'h00000055, 4'h3);
  endtask

  task automatic build_short();
    put_single(20'h00040, 32'h00001111, 4'hF);
    put_burst(20'h00044, 5, 32'hA000_0000);
  endtask

  initial begin : stimulus
    logic [31:0] len;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !error && !enabled, "R1", "status after reset", 64'({busy, error, enabled}), 64'd0);
    check(!rd_req_valid && !wr_valid, "R1", "ports idle after reset", 64'({rd_req_valid, wr_valid}), 64'd0);

    // Main program: singles, bursts, zero-count, opcode-0 slot
    cfg_write(SEL_CTRL, 32'd1);
    check(enabled == 1'b1, "R2", "enable bit set", 64'(enabled), 64'd1);
    build_main();
    load(32'h1000, len);
    cfg_write(SEL_HEAD, 32'h1000);
    start_run(32'h1000, 32'h1000 + len);
    finish_run(int'(len / 8));
    check(wr_cnt == 8, "R7", "write count with skipped slots", 64'(wr_cnt), 64'd8);

    // R3: configuration writes during a run
    build_short();
    load(32'h2000, len);
    record = 1'b0;
    put_single(20'h00099, 32'h00000BAD, 4'hF);
    load(32'h3000, len);
    record = 1'b1;
    cfg_write(SEL_HEAD, 32'h2000);
    start_run(32'h2000, 32'h2040);
    cfg_write(SEL_HEAD, 32'h3000);
    cfg_write(SEL_TAIL, 32'h3040);
    cfg_write(SEL_CTRL, 32'd0);
    check(enabled == 1'b1, "R3", "enable kept during run", 64'(enabled), 64'd1);
    finish_run(8);
    build_short();
    load(32'h2000, len);
    start_run(32'h2000, 32'h2040);   // same start pointer must still be in place (R3)
    finish_run(8);

    // R2: disabled engine and equal pointers do not start
    cfg_write(SEL_CTRL, 32'd0);
    check(enabled == 1'b0, "R2", "enable bit cleared", 64'(enabled), 64'd0);
    cfg_write(SEL_HEAD, 32'h1000);
    req_cnt = 0;
    cfg_write(SEL_TAIL, 32'h1080);
    repeat (3) @(negedge clk);
    check(!busy && req_cnt == 0, "R2", "no run while disabled", 64'({busy, 8'(req_cnt)}), 64'd0);
    cfg_write(SEL_CTRL, 32'd1);
    cfg_write(SEL_TAIL, 32'h1000);
    repeat (3) @(negedge clk);
    check(!busy && req_cnt == 0, "R2", "no run when pointers equal", 64'({busy, 8'(req_cnt)}), 64'd0);

    // R8: unknown opcode halts and sets error
    put_single(20'h00020, 32'h0000000A, 4'hF);
    words.push_back(32'd0); words.push_back(32'h7700_0000);
    record = 1'b0;
    put_single(20'h00030, 32'h0000000B, 4'hF);
    record = 1'b1;
    load(32'h4000, len);
    cfg_write(SEL_HEAD, 32'h4000);
    start_run(32'h4000, 32'h4000 + len);
    finish_run(2);
    check(error == 1'b1, "R8", "error after unknown opcode", 64'(error), 64'd1);

    // R8: next run clears the flag
    build_main();
    load(32'h1000, len);
    cfg_write(SEL_HEAD, 32'h1000);
    start_run(32'h1000, 32'h1000 + len);
    check(error == 1'b0, "R8", "error cleared by new run", 64'(error), 64'd0);
    finish_run(int'(len / 8));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    #(8 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule